// File: doc/BRIEF.md
# Parallel Port Controller with Extended Control and Byte FIFO

This block is the register file and data path of a PC-style parallel port with a byte FIFO. An 8-bit host bus reaches a low bank of three registers: data, status and control. It also reaches a high bank, starting at a parameterised base, that holds the FIFO window (which also serves as configuration A), configuration B and the extended control register (ECR). The ECR mode field sets how the FIFO is used. In the two lowest modes the FIFO is held empty. In the FIFO modes the host can push bytes. In test mode the host can push and pop bytes to find the depth and the thresholds. In configuration mode the two configuration registers are visible.

A service-interrupt flag in the ECR is cleared by software. Hardware sets it again when FIFO occupancy reaches a threshold. In the forward direction the threshold is free space. In the reverse direction it is filled entries. In the parallel FIFO mode with forward direction, a drain engine takes one byte whenever the peripheral is not busy, puts it on the data pins and raises a strobe for a fixed number of clocks.

Top module: `ecp_port_ctrl`

## Requirements
- R1: After reset the ECR reads 0x15 (mode 000, error-interrupt enable 1, DMA enable 0, service 1, not full, empty), the control register reads 0x00, pd_oe_o is 1 and strobe_o is 0.
- R2: ECR layout: bits 7:5 are the mode, bit 4 is the error-interrupt enable, bit 3 is the DMA enable, bit 2 is service-interrupt, bit 1 is 1 exactly when the FIFO holds DEPTH bytes, and bit 0 is 1 exactly when it holds none. Bits 1:0 ignore writes. Writing 0x34 in mode 000 reads back 0x35.
- R3: Writing mode 000 or 001 empties the FIFO on that write. The ECR reads empty on the very next access, and the FIFO stays empty while either mode is held.
- R4: A write that would change the mode from a value of 2 or more to a different value of 2 or more leaves the mode unchanged. Bits 4:2 still take the written value. Any write of mode 000 or 001 is accepted.
- R5: In modes 010, 011 and 110, host writes to offset HI_BASE+0 push a byte unless the FIFO is full, and a push into a full FIFO is dropped. In mode 110, host reads of that offset return the oldest byte and pop it.
- R6: With control bit 5 at 0, in modes 010, 011 or 110, a cleared service bit is set one clock after occupancy is at or below DEPTH-WR_THR. It stays 0 while occupancy is above that level.
- R7: With control bit 5 at 1, in modes 010, 011 or 110, a cleared service bit is set one clock after occupancy is at or above RD_THR. It stays 0 below that level.
- R8: In mode 111, reads of HI_BASE+1 return {00000, dma[2:0]}, where dma resets to 000 (no programmable channel). Writes there set dma only in mode 111 and are ignored in other modes. Reads of HI_BASE+0 return configuration A, which is CFG_A (0x10).
- R9: Control register bit 5 gives the data direction. When it is 1, pd_oe_o is 0 and a data register read returns pd_i. When it is 0, pd_oe_o is 1 and the read returns the last written data byte, which also drives pd_o.
- R10: In mode 010 with control bit 5 at 0, while busy_i is low and the FIFO is not empty, the block pops one byte, puts it on pd_o and holds strobe_o high for STB_CYC clocks. After each strobe it is idle for at least one clock. Bytes leave in FIFO order, and no byte is taken while busy_i is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Host register offset |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe; pops the FIFO in test mode |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data, combinational from addr_i |
| pd_i | input | 8 | External data lines |
| pd_o | output | 8 | Data line drive value |
| pd_oe_o | output | 1 | Data line output enable |
| stat_i | input | 5 | Peripheral status lines, read as status bits 7:3 |
| busy_i | input | 1 | Peripheral busy |
| strobe_o | output | 1 | Data strobe pulse, active high |

## Verification
The assertions assume that the host never asserts wr_i and rd_i in the same clock. They also assume that addr_i is steady whenever either strobe is high, and that busy_i changes only between clock edges. The bench drives every bus access at the falling edge, keeps each strobe high for one clock, and changes busy_i only from its sequencing block. A behavioural model holds the FIFO as a queue. On every clock it is compared with the data pins, the output enable, the strobe, ECR reads and test-mode FIFO reads.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  localparam int DW = 8;

  localparam logic [2:0] MODE_STD   = 3'b000;
  localparam logic [2:0] MODE_BIDIR = 3'b001;
  localparam logic [2:0] MODE_PFIFO = 3'b010;
  localparam logic [2:0] MODE_ECPF  = 3'b011;
  localparam logic [2:0] MODE_TEST  = 3'b110;
  localparam logic [2:0] MODE_CFG   = 3'b111;

  typedef struct packed {
    logic nerr_ie;
    logic dma_en;
    logic serv;
  } ecr_ctl_t;

  function automatic logic fifo_active(input logic [2:0] m);
    return (m == MODE_PFIFO) || (m == MODE_ECPF) || (m == MODE_TEST);
  endfunction

  function automatic logic fifo_held(input logic [2:0] m);
    return m < 3'd2;
  endfunction
endpackage

// File: rtl/ppc_fifo.sv
module ppc_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i && !clr_i) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else if (clr_i) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= nxt(wp_q);
      if (pop_i)  rp_q <= nxt(rp_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout_o  = mem_q[rp_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  assert_push_guard_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_pop_guard_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/ppc_drain.sv
module ppc_drain #(
  parameter int W       = 8,
  parameter int STB_CYC = 4,
  localparam int SW     = $clog2(STB_CYC + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic [W-1:0] head_i,
  output logic         pop_o,
  output logic [W-1:0] byte_o,
  output logic         strobe_o
);
  logic [SW-1:0] cnt_q;
  logic [W-1:0]  byte_q;

  assign pop_o    = go_i && (cnt_q == '0);
  assign strobe_o = (cnt_q != '0);
  assign byte_o   = byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      byte_q <= '0;
    end else if (pop_o) begin
      cnt_q  <= SW'(STB_CYC);
      byte_q <= head_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_pop_strobe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> strobe_o && (byte_o == $past(head_i)));
  assert_strobe_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strobe_o) |-> $past(pop_o));
endmodule

// File: rtl/ppc_ecr.sv
module ppc_ecr
  import ppc_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WR_THR = 8,
  parameter int RD_THR = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          dir_i,
  input  logic [CW-1:0] count_i,
  input  logic          full_i,
  input  logic          empty_i,
  output logic [2:0]    mode_o,
  output logic [DW-1:0] ecr_o,
  output logic          clr_o
);
  logic [2:0] mode_q, mode_wr;
  ecr_ctl_t   ctl_q;
  logic       hop, hit;

  assign mode_wr = wdata_i[7:5];
  // a jump between two FIFO-class modes is refused
  assign hop = (mode_q >= 3'd2) && (mode_wr >= 3'd2);
  assign hit = fifo_active(mode_q) &&
               (dir_i ? (count_i >= CW'(RD_THR)) : (count_i <= CW'(DEPTH - WR_THR)));
  assign clr_o = fifo_held(mode_q) || (we_i && fifo_held(mode_wr));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_STD;
      ctl_q  <= '{nerr_ie: 1'b1, dma_en: 1'b0, serv: 1'b1};
    end else if (we_i) begin
      if (!hop) mode_q <= mode_wr;
      ctl_q <= ecr_ctl_t'(wdata_i[4:2]);
    end else if (!ctl_q.serv && hit) begin
      ctl_q.serv <= 1'b1;
    end
  end

  assign mode_o = mode_q;
  assign ecr_o  = {mode_q, ctl_q, full_i, empty_i};

  assert_mode_hop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && (mode_q >= 3'd2) && (wdata_i[7:5] >= 3'd2) |=> mode_o == $past(mode_q));
  assert_held_empty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_held(mode_o) |-> empty_i);
  assert_serv_fwd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i && !ecr_o[2] && fifo_active(mode_o) && !dir_i && (count_i <= CW'(DEPTH - WR_THR))
    |=> ecr_o[2]);
  assert_serv_rev_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i && !ecr_o[2] && fifo_active(mode_o) && dir_i && (count_i >= CW'(RD_THR))
    |=> ecr_o[2]);
  assert_flags_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_i && empty_i));
endmodule

// File: rtl/ecp_port_ctrl.sv
module ecp_port_ctrl
  import ppc_pkg::*;
#(
  parameter int          AW      = 11,
  parameter int          HI_BASE = 1024,
  parameter int          DEPTH   = 16,
  parameter int          WR_THR  = 8,
  parameter int          RD_THR  = 8,
  parameter int          STB_CYC = 4,
  parameter logic [7:0]  CFG_A   = 8'h10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] pd_i,
  output logic [DW-1:0] pd_o,
  output logic          pd_oe_o,
  input  logic [4:0]    stat_i,
  input  logic          busy_i,
  output logic          strobe_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] A_DATA = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_CTRL = AW'(2);
  localparam logic [AW-1:0] A_FIFO = AW'(HI_BASE);
  localparam logic [AW-1:0] A_CFGB = AW'(HI_BASE + 1);
  localparam logic [AW-1:0] A_ECR  = AW'(HI_BASE + 2);

  logic [DW-1:0] data_q, ctrl_q, ecr, head, drain_byte;
  logic [2:0]    dma_q, mode;
  logic [CW-1:0] count;
  logic          full, empty, clr, push, host_pop, drain_pop, drain_go, stb, dir;

  assign dir = ctrl_q[5];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      ctrl_q <= '0;
      dma_q  <= '0;
    end else if (wr_i) begin
      if (addr_i == A_DATA) data_q <= wdata_i;
      if (addr_i == A_CTRL) ctrl_q <= wdata_i;
      if (addr_i == A_CFGB && mode == MODE_CFG) dma_q <= wdata_i[2:0];
    end
  end

  assign push     = wr_i && (addr_i == A_FIFO) && fifo_active(mode) && !full;
  assign host_pop = rd_i && (addr_i == A_FIFO) && (mode == MODE_TEST) && !empty;
  assign drain_go = (mode == MODE_PFIFO) && !dir && !empty && !busy_i;

  ppc_ecr #(.DEPTH(DEPTH), .WR_THR(WR_THR), .RD_THR(RD_THR)) i_ecr (
    .clk_i, .rst_ni,
    .we_i    (wr_i && (addr_i == A_ECR)),
    .wdata_i,
    .dir_i   (dir),
    .count_i (count),
    .full_i  (full),
    .empty_i (empty),
    .mode_o  (mode),
    .ecr_o   (ecr),
    .clr_o   (clr)
  );

  ppc_fifo #(.DEPTH(DEPTH), .W(DW)) i_fifo (
    .clk_i, .rst_ni,
    .clr_i   (clr),
    .push_i  (push),
    .din_i   (wdata_i),
    .pop_i   (host_pop || drain_pop),
    .dout_o  (head),
    .count_o (count),
    .full_o  (full),
    .empty_o (empty)
  );

  ppc_drain #(.W(DW), .STB_CYC(STB_CYC)) i_drain (
    .clk_i, .rst_ni,
    .go_i     (drain_go),
    .head_i   (head),
    .pop_o    (drain_pop),
    .byte_o   (drain_byte),
    .strobe_o (stb)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_DATA: rdata_o = dir ? pd_i : data_q;
      A_STAT: rdata_o = {stat_i, 3'b000};
      A_CTRL: rdata_o = ctrl_q;
      A_FIFO: rdata_o = (mode == MODE_TEST) ? head : (mode == MODE_CFG) ? CFG_A : '0;
      A_CFGB: rdata_o = (mode == MODE_CFG) ? {5'b0, dma_q} : '0;
      A_ECR:  rdata_o = ecr;
      default: rdata_o = '0;
    endcase
  end

  assign pd_o     = stb ? drain_byte : data_q;
  assign pd_oe_o  = !dir;
  assign strobe_o = stb;

  assert_busy_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_pop |-> !busy_i && (mode == MODE_PFIFO) && pd_oe_o);
  assert_cfgb_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && (addr_i == A_CFGB) && (mode != MODE_CFG) |=> $stable(dma_q));
  assert_no_mix_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_pop && drain_pop));
endmodule

// File: tb/test_ecp_port_ctrl.sv
module test_ecp_port_ctrl;
  localparam int DEPTH = 16, WR_THR = 8, RD_THR = 8, STB = 4;
  localparam logic [10:0] A_DATA = 11'h000, A_CTRL = 11'h002;
  localparam logic [10:0] A_FIFO = 11'h400, A_CFGB = 11'h401, A_ECR = 11'h402;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, busy = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0] wdata = '0, rdata, pd_in = 8'hA5, pd_out;
  logic pd_oe, strobe;

  ecp_port_ctrl i_ecp_port_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr_en), .rd_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata), .pd_i(pd_in), .pd_o(pd_out), .pd_oe_o(pd_oe),
    .stat_i(5'b10101), .busy_i(busy), .strobe_o(strobe)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [2:0] m_mode, m_bits, m_dma, om, nm;
  logic [7:0] m_ctrl, m_data, m_byte;
  logic [7:0] q[$];
  logic [7:0] cap[$];
  int m_st, sz;
  logic hit, dpop, hpop, push, clr, prev_stb;

  function automatic logic fm(input logic [2:0] m);
    return m == 3'd2 || m == 3'd3 || m == 3'd6;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 3'd0; m_bits = 3'b101; m_dma = 3'd0;
      m_ctrl = 8'h00; m_data = 8'h00; m_byte = 8'h00; m_st = 0;
      q.delete();
    end else begin
      om   = m_mode;
      sz   = q.size();
      hit  = fm(om) && (m_ctrl[5] ? (sz >= RD_THR) : (sz <= DEPTH - WR_THR));
      dpop = (m_st == 0) && om == 3'd2 && !m_ctrl[5] && sz > 0 && !busy;
      hpop = rd_en && addr == A_FIFO && om == 3'd6 && sz > 0;
      push = wr_en && addr == A_FIFO && fm(om) && sz < DEPTH;
      clr  = om < 3'd2 || (wr_en && addr == A_ECR && wdata[7:5] < 3'd2);
      if (m_st > 0) m_st = m_st - 1;
      else if (dpop) begin m_byte = q[0]; m_st = STB; end
      if (clr) q.delete();
      else begin
        if (dpop || hpop) void'(q.pop_front());
        if (push) q.push_back(wdata);
      end
      if (wr_en && addr == A_ECR) begin
        nm = wdata[7:5];
        if (!(om >= 3'd2 && nm >= 3'd2)) m_mode = nm;
        m_bits = wdata[4:2];
      end else if (!m_bits[0] && hit) m_bits[0] = 1'b1;
      if (wr_en && addr == A_DATA) m_data = wdata;
      if (wr_en && addr == A_CTRL) m_ctrl = wdata;
      if (wr_en && addr == A_CFGB && om == 3'd7) m_dma = wdata[2:0];
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      check("R10 strobe", int'(strobe), int'(m_st != 0));
      check("R9 pd_o", int'(pd_out), int'((m_st != 0) ? m_byte : m_data));
      check("R9 pd_oe", int'(pd_oe), int'(!m_ctrl[5]));
      if (rd_en && addr == A_ECR)
        check("R2 ecr model", int'(rdata),
              int'({m_mode, m_bits, q.size() == DEPTH, q.size() == 0}));
      if (rd_en && addr == A_FIFO && m_mode == 3'd6 && q.size() > 0)
        check("R5 fifo head", int'(rdata), int'(q[0]));
      if (strobe && !prev_stb) cap.push_back(pd_out);
      prev_stb = strobe;
    end else prev_stb = 1'b0;
  end

  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 check(tag, int'(rdata), int'(exp));
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    #1 check("R1 oe", int'(pd_oe), 1);
    check("R1 strobe", int'(strobe), 0);
    rd(A_ECR, 8'h15, "R1 ecr");
    rd(A_CTRL, 8'h00, "R1 ctrl");
    // R2 empty flag shows through a written value
    wr(A_ECR, 8'h34);
    rd(A_ECR, 8'h35, "R2 0x34 readback");
    // R5 test mode fill
    wr(A_ECR, 8'hD4);
    rd(A_ECR, 8'hD5, "R5 test empty");
    for (int i = 0; i < DEPTH; i++) wr(A_FIFO, 8'h10 + 8'(i));
    rd(A_ECR, 8'hD6, "R5 full");
    wr(A_FIFO, 8'hEE);
    rd(A_ECR, 8'hD6, "R5 push on full dropped");
    // R4 refused hop, bits still written
    wr(A_ECR, 8'h5C);
    rd(A_ECR, 8'hDE, "R4 hop refused");
    wr(A_ECR, 8'hD4);
    // R6 forward threshold
    wr(A_ECR, 8'hD0);
    rd(A_ECR, 8'hD2, "R6 serv cleared");
    for (int i = 0; i < 7; i++) rd(A_FIFO, 8'h10 + 8'(i), "R5 pop order");
    idle(1);
    rd(A_ECR, 8'hD0, "R6 above threshold");
    rd(A_FIFO, 8'h17, "R5 pop order");
    idle(1);
    rd(A_ECR, 8'hD4, "R6 threshold set");
    for (int i = 0; i < 8; i++) rd(A_FIFO, 8'h18 + 8'(i), "R5 pop order");
    idle(1);
    rd(A_ECR, 8'hD5, "R5 drained");
    // R7 reverse threshold
    wr(A_CTRL, 8'h20);
    wr(A_ECR, 8'h34);
    wr(A_ECR, 8'hD0);
    for (int i = 0; i < 7; i++) wr(A_FIFO, 8'h60 + 8'(i));
    idle(1);
    rd(A_ECR, 8'hD0, "R7 below threshold");
    wr(A_FIFO, 8'h67);
    idle(1);
    rd(A_ECR, 8'hD4, "R7 threshold set");
    // R3 bidirectional mode empties
    wr(A_ECR, 8'h34);
    rd(A_ECR, 8'h35, "R3 cleared");
    // R9 direction
    wr(A_DATA, 8'h3C);
    rd(A_DATA, 8'hA5, "R9 reverse read");
    rd(A_CTRL, 8'h20, "R9 ctrl");
    wr(A_CTRL, 8'h00);
    rd(A_DATA, 8'h3C, "R9 forward read");
    // R8 configuration
    wr(A_ECR, 8'hF4);
    rd(A_ECR, 8'hF5, "R8 cfg mode");
    rd(A_CFGB, 8'h00, "R8 no channel");
    wr(A_CFGB, 8'h03);
    rd(A_CFGB, 8'h03, "R8 channel");
    rd(A_FIFO, 8'h10, "R8 cfg a");
    wr(A_ECR, 8'hD4);
    rd(A_ECR, 8'hF5, "R4 cfg to test refused");
    wr(A_ECR, 8'h34);
    wr(A_CFGB, 8'h05);
    wr(A_ECR, 8'hF4);
    rd(A_CFGB, 8'h03, "R8 write outside cfg ignored");
    // R10 drain
    wr(A_ECR, 8'h34);
    busy = 1'b1;
    wr(A_ECR, 8'h54);
    wr(A_FIFO, 8'hA1); wr(A_FIFO, 8'hA2); wr(A_FIFO, 8'hA3);
    idle(10);
    check("R10 no drain while busy", cap.size(), 0);
    rd(A_ECR, 8'h54, "R10 held");
    @(negedge clk); busy = 1'b0;
    idle(25);
    check("R10 byte count", cap.size(), 3);
    if (cap.size() == 3) begin
      check("R10 byte 0", int'(cap[0]), 8'hA1);
      check("R10 byte 1", int'(cap[1]), 8'hA2);
      check("R10 byte 2", int'(cap[2]), 8'hA3);
    end
    rd(A_ECR, 8'h55, "R10 empty after drain");
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule